// File: doc/BRIEF.md
# Banked UART Extended Register Front-End

This block sits between a byte-wide register bus and a 16550-compatible UART core. It owns the extended control registers that the plain core lacks, and it passes every access it does not claim straight through to the core on a forward port. Which registers an offset reaches depends on an internal bank state. Writes to the line-control offset change that state as a side effect. A separate register-swap condition, made from an enhanced-enable bit and a cached modem-control bit, can override the bank at two offsets.

A read strobe produces registered read data one cycle later, whether the data came from a local register or from the core. The core must return its read data in the same cycle as the forwarded read strobe. A write to the system-configuration register with the soft-reset bit set returns the local registers to their reset state. Offsets that the block does not define read zero, cause no write and raise a one-cycle error flag.

Top module: `uart_xreg_front`

## Requirements
- R1: A write to offset 0x0C is always forwarded. It also sets the bank. The value 0xBF selects bank B. Any other value with bit 7 set selects bank A. Every other value selects the operational bank, which is the bank after reset.
- R2: Offset 0x08 reads and writes the local enhanced-feature byte only in bank B. In the other banks the access is forwarded.
- R3: In bank B, offsets 0x10/0x14 reach two local XON bytes, and offsets 0x18/0x1C reach two local XOFF bytes. Address bit 2 selects the byte within each pair.
- R4: When enhanced-feature bit 4 and cached modem-control bit 6 are both 1, offset 0x18 reaches the transmit-control byte and 0x1C reaches the trigger-level byte, in every bank. Outside this condition and outside bank B, both offsets are forwarded.
- R5: Outside bank B, a write to 0x10 is forwarded. If enhanced-feature bit 4 is 1, the same write also stores data bits 6:5 in a local cache. A read of 0x10 outside bank B returns the core's data ORed with the cache. 0x14 is forwarded outside bank B.
- R6: The baud-level byte (0x38) keeps bits 7:6 and the auxiliary-control byte (0x3C) keeps all 8 bits. Both take writes only in the operational bank, and both read 0 in banks A and B.
- R7: Storage masks: 0x20 keeps 0x7F, 0x24 keeps 0xFF, 0x4C keeps 0x01, 0x54 keeps 0x1D, 0x5C keeps 0x7F. Offsets 0x40, 0x48 and 0x60 keep all 8 bits.
- R8: A write to 0x54 with bit 1 set restores every local register to its reset value, so 0x54 then reads 0. The bytes at 0x20, 0x24 and 0x40 are left unchanged.
- R9: Reset values: 0x5C=0x3F, 0x60=0x69, 0x38=0x40, transmit-control=0x0F, operational bank. All other local bytes are 0, including 0x20, 0x24 and 0x40 after a hardware reset.
- R10: 0x50 reads 0x30 and 0x58 reads 0x01. 0x28, 0x2C, 0x30, 0x34 and 0x44 read 0. Writes to all of these offsets are ignored and are not forwarded.
- R11: Offsets 0x00 and 0x04 are always forwarded, and so are reads of 0x0C.
- R12: Forward strobes are asserted in the same cycle as the bus strobe, and only for forwarded offsets. Read data appears one cycle after the read strobe on both paths.
- R13: An offset that is not a multiple of 4 in 0x00–0x60, or any offset above 0x60, reads 0, writes nothing, is not forwarded, and raises the error flag for exactly the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bad_access | output | 1 | One-cycle pulse after an access to an undefined offset |
| fwd_addr | output | ADDR_W | Offset presented to the core |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_rd | output | 1 | Forwarded read strobe |
| fwd_wdata | output | DATA_W | Write data presented to the core |
| fwd_rdata | input | DATA_W | Core read data, valid in the forwarded read cycle |

## Verification
Assertions check on every cycle that the 0xBF key selects bank B, that the baud-level byte holds still while out of the operational bank, that a soft reset clears the bank, the enhanced-feature byte and the configuration byte, that forward strobes follow the bus strobes, and that the error flag follows only an access. The bench's scenarios cover the rest: the priority of the swap condition over bank B, the OR of the cache into the core's modem-control data, the masks, and the registers a soft reset must leave untouched.

// File: rtl/uart_xreg_pkg.sv
package uart_xreg_pkg;

   typedef enum logic [1:0] {
      BANK_OP   = 2'd0,
      BANK_A    = 2'd1,
      BANK_B    = 2'd2
   } xbank_t;

   typedef enum logic [4:0] {
      T_FWD, T_LCR, T_MCR, T_EFR, T_XON, T_XOFF, T_TCR, T_TLR,
      T_MDR1, T_MDR2, T_ZERO, T_BLR, T_ACR, T_SCR, T_EBLR, T_CLK,
      T_VER, T_SYSC, T_SYSS, T_WER, T_CFPS, T_BAD
   } xtgt_t;

   localparam logic [7:0] BANK_B_KEY   = 8'hBF;
   localparam logic [7:0] MDR1_MASK    = 8'h7F;
   localparam logic [7:0] MDR2_MASK    = 8'hFF;
   localparam logic [7:0] BLR_MASK     = 8'hC0;
   localparam logic [7:0] CLK_MASK     = 8'h01;
   localparam logic [7:0] SYSC_MASK    = 8'h1D;
   localparam logic [7:0] WER_MASK     = 8'h7F;
   localparam logic [7:0] MCR_MASK     = 8'h60;
   localparam int         SOFT_RST_BIT = 1;
   localparam int         ENH_EN_BIT   = 4;
   localparam int         MCR_SWAP_BIT = 6;

   typedef struct packed {
      xbank_t     bank;
      logic [7:0] efr;
      logic [7:0] tcr;
      logic [7:0] tlr;
      logic [7:0] mcr;
      logic [7:0] blr;
      logic [7:0] acr;
      logic [7:0] eblr;
      logic [7:0] clk;
      logic [7:0] sysc;
      logic [7:0] wer;
      logic [7:0] cfps;
   } xregs_t;

   function automatic logic tgt_forwards(input xtgt_t t);
      return (t == T_FWD) || (t == T_LCR) || (t == T_MCR);
   endfunction

endpackage

// File: rtl/uart_xreg_decode.sv
module uart_xreg_decode
   import uart_xreg_pkg::*;
(
   input  logic [7:0] offset,
   input  xbank_t     bank,
   input  logic       swap,
   output xtgt_t      tgt
);
   logic in_b;
   assign in_b = (bank == BANK_B);

   always_comb begin
      unique case (offset)
         8'h00, 8'h04:               tgt = T_FWD;
         8'h08:                      tgt = in_b ? T_EFR : T_FWD;
         8'h0C:                      tgt = T_LCR;
         8'h10:                      tgt = in_b ? T_XON : T_MCR;
         8'h14:                      tgt = in_b ? T_XON : T_FWD;
         8'h18:                      tgt = swap ? T_TCR : (in_b ? T_XOFF : T_FWD);
         8'h1C:                      tgt = swap ? T_TLR : (in_b ? T_XOFF : T_FWD);
         8'h20:                      tgt = T_MDR1;
         8'h24:                      tgt = T_MDR2;
         8'h28, 8'h2C, 8'h30, 8'h34,
         8'h44:                      tgt = T_ZERO;
         8'h38:                      tgt = T_BLR;
         8'h3C:                      tgt = T_ACR;
         8'h40:                      tgt = T_SCR;
         8'h48:                      tgt = T_EBLR;
         8'h4C:                      tgt = T_CLK;
         8'h50:                      tgt = T_VER;
         8'h54:                      tgt = T_SYSC;
         8'h58:                      tgt = T_SYSS;
         8'h5C:                      tgt = T_WER;
         8'h60:                      tgt = T_CFPS;
         default:                    tgt = T_BAD;
      endcase
   end
endmodule

// File: rtl/uart_xreg_bank.sv
module uart_xreg_bank
   import uart_xreg_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter logic [7:0] WER_RST  = 8'h3F,
   parameter logic [7:0] CFPS_RST = 8'h69,
   parameter logic [7:0] BLR_RST  = 8'h40,
   parameter logic [7:0] TCR_RST  = 8'h0F,
   parameter logic [7:0] VERSION  = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  xtgt_t             tgt,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output xbank_t            bank,
   output logic              swap,
   output logic [DATA_W-1:0] mcr_cache,
   output logic [DATA_W-1:0] rdata
);
   localparam int FLOW_BYTES = 2;

   localparam xregs_t REGS_RST = '{
      bank: BANK_OP, efr: 8'h00, tcr: TCR_RST, tlr: 8'h00, mcr: 8'h00,
      blr: BLR_RST, acr: 8'h00, eblr: 8'h00, clk: 8'h00, sysc: 8'h00,
      wer: WER_RST, cfps: CFPS_RST };

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_xreg_bank: DATA_W must be 8");
      end
   endgenerate

   xregs_t     regs_q, regs_d;
   logic [7:0] mdr1_q, mdr2_q, scr_q;
   logic [7:0] xon_q  [FLOW_BYTES];
   logic [7:0] xoff_q [FLOW_BYTES];
   logic       soft_rst;
   logic       in_op;

   assign in_op    = (regs_q.bank == BANK_OP);
   assign soft_rst = wr_en && (tgt == T_SYSC) && wdata[SOFT_RST_BIT];

   always_comb begin
      regs_d = regs_q;
      if (wr_en) begin
         unique case (tgt)
            T_LCR: begin
               if (wdata == BANK_B_KEY)  regs_d.bank = BANK_B;
               else if (wdata[7])        regs_d.bank = BANK_A;
               else                      regs_d.bank = BANK_OP;
            end
            T_MCR:  if (regs_q.efr[ENH_EN_BIT]) regs_d.mcr = wdata & MCR_MASK;
            T_EFR:  regs_d.efr  = wdata;
            T_TCR:  regs_d.tcr  = wdata;
            T_TLR:  regs_d.tlr  = wdata;
            T_BLR:  if (in_op) regs_d.blr = wdata & BLR_MASK;
            T_ACR:  if (in_op) regs_d.acr = wdata;
            T_EBLR: regs_d.eblr = wdata;
            T_CLK:  regs_d.clk  = wdata & CLK_MASK;
            T_SYSC: regs_d.sysc = wdata & SYSC_MASK;
            T_WER:  regs_d.wer  = wdata & WER_MASK;
            T_CFPS: regs_d.cfps = wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q <= REGS_RST;
      else if (soft_rst) regs_q <= REGS_RST;
      else               regs_q <= regs_d;
   end

   // Mode-definition and scratch bytes survive a soft reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdr1_q <= '0;
         mdr2_q <= '0;
         scr_q  <= '0;
      end else if (wr_en) begin
         if (tgt == T_MDR1) mdr1_q <= wdata & MDR1_MASK;
         if (tgt == T_MDR2) mdr2_q <= wdata & MDR2_MASK;
         if (tgt == T_SCR)  scr_q  <= wdata;
      end
   end

   generate
      for (genvar g = 0; g < FLOW_BYTES; g++) begin : g_flow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               xon_q[g]  <= '0;
               xoff_q[g] <= '0;
            end else if (soft_rst) begin
               xon_q[g]  <= '0;
               xoff_q[g] <= '0;
            end else if (wr_en && (sel == 1'(g))) begin
               if (tgt == T_XON)  xon_q[g]  <= wdata;
               if (tgt == T_XOFF) xoff_q[g] <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      unique case (tgt)
         T_EFR:  rdata = regs_q.efr;
         T_XON:  rdata = xon_q[sel];
         T_XOFF: rdata = xoff_q[sel];
         T_TCR:  rdata = regs_q.tcr;
         T_TLR:  rdata = regs_q.tlr;
         T_MDR1: rdata = mdr1_q;
         T_MDR2: rdata = mdr2_q;
         T_BLR:  rdata = in_op ? regs_q.blr : 8'h00;
         T_ACR:  rdata = in_op ? regs_q.acr : 8'h00;
         T_SCR:  rdata = scr_q;
         T_EBLR: rdata = regs_q.eblr;
         T_CLK:  rdata = regs_q.clk;
         T_VER:  rdata = VERSION;
         T_SYSC: rdata = regs_q.sysc;
         T_SYSS: rdata = 8'h01;
         T_WER:  rdata = regs_q.wer;
         T_CFPS: rdata = regs_q.cfps;
         default: rdata = 8'h00;
      endcase
   end

   assign bank      = regs_q.bank;
   assign mcr_cache = regs_q.mcr;
   assign swap      = regs_q.efr[ENH_EN_BIT] && regs_q.mcr[MCR_SWAP_BIT];

   // R1: the key value always lands in bank B
   a_r1_key_selects_b: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tgt == T_LCR && wdata == BANK_B_KEY) |=> (bank == BANK_B));

   // R6: baud-level byte frozen outside the operational bank
   a_r6_blr_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tgt == T_BLR && !in_op) |=> $stable(regs_q.blr));

   // R8: soft reset returns bank, enhanced byte and configuration byte to reset
   a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tgt == T_SYSC && wdata[SOFT_RST_BIT])
      |=> (bank == BANK_OP && regs_q.efr == 8'h00 && regs_q.sysc == 8'h00));
endmodule

// File: rtl/uart_xreg_front.sv
module uart_xreg_front
   import uart_xreg_pkg::*;
#(
   parameter int         ADDR_W   = 8,
   parameter int         DATA_W   = 8,
   parameter logic [7:0] WER_RST  = 8'h3F,
   parameter logic [7:0] CFPS_RST = 8'h69,
   parameter logic [7:0] BLR_RST  = 8'h40,
   parameter logic [7:0] TCR_RST  = 8'h0F,
   parameter logic [7:0] VERSION  = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bad_access,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              fwd_wr,
   output logic              fwd_rd,
   output logic [DATA_W-1:0] fwd_wdata,
   input  logic [DATA_W-1:0] fwd_rdata
);
   localparam int SEL_BIT = 2;

   generate
      if (ADDR_W != 8) begin : g_bad_addr
         $error("uart_xreg_front: ADDR_W must be 8");
      end
   endgenerate

   xbank_t            bank;
   logic              swap;
   xtgt_t             tgt;
   logic              fwd_hit;
   logic [DATA_W-1:0] mcr_cache, local_rdata, fwd_merged;

   uart_xreg_decode u_decode (
      .offset (bus_addr[7:0]),
      .bank   (bank),
      .swap   (swap),
      .tgt    (tgt)
   );

   uart_xreg_bank #(
      .DATA_W   (DATA_W),
      .WER_RST  (WER_RST),
      .CFPS_RST (CFPS_RST),
      .BLR_RST  (BLR_RST),
      .TCR_RST  (TCR_RST),
      .VERSION  (VERSION)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .tgt       (tgt),
      .sel       (bus_addr[SEL_BIT]),
      .wdata     (bus_wdata),
      .bank      (bank),
      .swap      (swap),
      .mcr_cache (mcr_cache),
      .rdata     (local_rdata)
   );

   assign fwd_hit    = tgt_forwards(tgt);
   assign fwd_addr   = bus_addr;
   assign fwd_wdata  = bus_wdata;
   assign fwd_wr     = bus_wr && fwd_hit;
   assign fwd_rd     = bus_rd && fwd_hit;
   assign fwd_merged = (tgt == T_MCR) ? (fwd_rdata | mcr_cache) : fwd_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bad_access <= 1'b0;
      end else begin
         bad_access <= (bus_rd || bus_wr) && (tgt == T_BAD);
         if (bus_rd) bus_rdata <= fwd_hit ? fwd_merged : local_rdata;
      end
   end

   // R12: forward strobes only accompany a bus strobe
   a_r12_fwd_follows_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_wr || fwd_rd) |-> (bus_wr || bus_rd));

   // R13: error flag only after an access, and undefined offsets never forward
   a_r13_bad_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(bus_rd || bus_wr));
   a_r13_bad_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == T_BAD) |-> (!fwd_wr && !fwd_rd));

   // R10: version offset reads its constant one cycle later
   a_r10_version_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[7:0] == 8'h50) |=> (bus_rdata == VERSION));
endmodule

// File: tb/uart_xreg_front_test.sv
module uart_xreg_front_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata, fwd_addr, fwd_wdata, fwd_rdata;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, bad_access, fwd_wr, fwd_rd;

   always #5 clk = ~clk;

   uart_xreg_front uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bad_access(bad_access),
      .fwd_addr(fwd_addr), .fwd_wr(fwd_wr), .fwd_rd(fwd_rd), .fwd_wdata(fwd_wdata),
      .fwd_rdata(fwd_rdata));

   // Stand-in core: data derived from the offset, bits 6:5 clear.
   assign fwd_rdata = {fwd_addr[7:2], 2'b10};

   int    checks = 0, fails = 0;
   string cur_req = "R9";
   bit    cmp_on = 0;

   // Behavioural reference state
   int         m_bank;   // 0 operational, 1 bank A, 2 bank B
   logic [7:0] m_efr, m_tcr, m_tlr, m_mcr, m_blr, m_acr, m_eblr, m_clk, m_sysc, m_wer, m_cfps;
   logic [7:0] m_mdr1, m_mdr2, m_scr;
   logic [7:0] m_xon[2], m_xoff[2];
   logic [7:0] ex_rdata = '0;
   logic       ex_bad = 1'b0;

   task automatic m_soft();
      m_bank = 0; m_efr = 0; m_tcr = 8'h0F; m_tlr = 0; m_mcr = 0; m_blr = 8'h40;
      m_acr = 0; m_eblr = 0; m_clk = 0; m_sysc = 0; m_wer = 8'h3F; m_cfps = 8'h69;
      m_xon[0] = 0; m_xon[1] = 0; m_xoff[0] = 0; m_xoff[1] = 0;
   endtask

   function automatic bit m_swap();
      return m_efr[4] && m_mcr[6];
   endfunction

   function automatic bit m_undef(input logic [7:0] a);
      return (a[1:0] != 2'b00) || (a > 8'h60);
   endfunction

   function automatic bit m_fwd(input logic [7:0] a);
      case (a)
         8'h00, 8'h04, 8'h0C:        return 1;
         8'h08, 8'h10, 8'h14:        return m_bank != 2;
         8'h18, 8'h1C:               return !m_swap() && m_bank != 2;
         default:                    return 0;
      endcase
   endfunction

   function automatic logic [7:0] m_read(input logic [7:0] a);
      logic [7:0] core = {a[7:2], 2'b10};
      if (m_fwd(a)) return (a == 8'h10) ? (core | m_mcr) : core;
      case (a)
         8'h08: return m_efr;
         8'h10, 8'h14: return m_xon[a[2]];
         8'h18: return m_swap() ? m_tcr : m_xoff[0];
         8'h1C: return m_swap() ? m_tlr : m_xoff[1];
         8'h20: return m_mdr1;
         8'h24: return m_mdr2;
         8'h38: return (m_bank == 0) ? m_blr : 8'h00;
         8'h3C: return (m_bank == 0) ? m_acr : 8'h00;
         8'h40: return m_scr;
         8'h48: return m_eblr;
         8'h4C: return m_clk;
         8'h50: return 8'h30;
         8'h54: return m_sysc;
         8'h58: return 8'h01;
         8'h5C: return m_wer;
         8'h60: return m_cfps;
         default: return 8'h00;
      endcase
   endfunction

   task automatic m_write(input logic [7:0] a, input logic [7:0] d);
      case (a)
         8'h0C: m_bank = (d == 8'hBF) ? 2 : (d[7] ? 1 : 0);
         8'h08: if (m_bank == 2) m_efr = d;
         8'h10, 8'h14: begin
            if (m_bank == 2) m_xon[a[2]] = d;
            else if (a == 8'h10 && m_efr[4]) m_mcr = d & 8'h60;
         end
         8'h18, 8'h1C: begin
            if (m_swap()) begin
               if (a == 8'h18) m_tcr = d; else m_tlr = d;
            end else if (m_bank == 2) m_xoff[a[2]] = d;
         end
         8'h20: m_mdr1 = d & 8'h7F;
         8'h24: m_mdr2 = d;
         8'h38: if (m_bank == 0) m_blr = d & 8'hC0;
         8'h3C: if (m_bank == 0) m_acr = d;
         8'h40: m_scr = d;
         8'h48: m_eblr = d;
         8'h4C: m_clk = d & 8'h01;
         8'h54: begin m_sysc = d & 8'h1D; if (d[1]) m_soft(); end
         8'h5C: m_wer = d & 8'h7F;
         8'h60: m_cfps = d;
         default: ;
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_soft(); m_mdr1 = 0; m_mdr2 = 0; m_scr = 0;
         ex_rdata = 0; ex_bad = 0;
      end else begin
         ex_bad = (bus_rd || bus_wr) && m_undef(bus_addr);
         if (bus_rd) ex_rdata = m_read(bus_addr);
         if (bus_wr) m_write(bus_addr, bus_wdata);
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison of registered outputs (R12 read latency on both paths)
   always @(negedge clk) begin
      if (cmp_on) begin
         chk(bus_rdata, ex_rdata, cur_req, "rdata");
         chk({7'b0, bad_access}, {7'b0, ex_bad}, cur_req, "bad_access");
      end
   end

   task automatic acc(input bit w, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d;
      #1;
      chk({7'b0, fwd_wr}, {7'b0, w && m_fwd(a)}, "R12", "fwd_wr");
      chk({7'b0, fwd_rd}, {7'b0, !w && m_fwd(a)}, "R12", "fwd_rd");
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d); acc(1'b1, a, d); endtask
   task automatic rd(input logic [7:0] a); acc(1'b0, a, 8'h00); endtask
   task automatic idle();
      @(negedge clk); bus_wr = 0; bus_rd = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(posedge clk); cmp_on = 1;
      repeat (2) @(negedge clk);
      rst_n = 1;
      cur_req = "R9";  rd(8'h5C); rd(8'h60); rd(8'h38); rd(8'h3C); rd(8'h08); rd(8'h20); idle();
      cur_req = "R10"; rd(8'h50); rd(8'h58); rd(8'h28); rd(8'h34); rd(8'h44);
                       wr(8'h2C, 8'hFF); wr(8'h50, 8'h12); wr(8'h58, 8'h00); rd(8'h2C); rd(8'h50); idle();
      cur_req = "R11"; rd(8'h00); wr(8'h04, 8'h55); rd(8'h04); rd(8'h0C); idle();
      cur_req = "R5";  wr(8'h10, 8'hFF); rd(8'h10); rd(8'h14); idle();
      cur_req = "R1";  wr(8'h0C, 8'h83); rd(8'h08); rd(8'h0C);
      cur_req = "R6";  rd(8'h38); wr(8'h38, 8'h00); wr(8'h3C, 8'h77); rd(8'h3C);
      cur_req = "R1";  wr(8'h0C, 8'hBF);
      cur_req = "R2";  wr(8'h08, 8'h10); rd(8'h08);
      cur_req = "R3";  wr(8'h10, 8'h11); wr(8'h14, 8'h13); wr(8'h18, 8'h22); wr(8'h1C, 8'h24);
                       rd(8'h10); rd(8'h14); rd(8'h18); rd(8'h1C);
      cur_req = "R1";  wr(8'h0C, 8'h03); rd(8'h08); idle();
      cur_req = "R5";  wr(8'h10, 8'h7F); rd(8'h10); idle();
      cur_req = "R4";  rd(8'h18); wr(8'h18, 8'h5A); wr(8'h1C, 8'hA5); rd(8'h18); rd(8'h1C);
                       wr(8'h0C, 8'hBF); rd(8'h18); rd(8'h1C); rd(8'h10); wr(8'h0C, 8'h00); idle();
      cur_req = "R6";  wr(8'h38, 8'hFF); rd(8'h38); wr(8'h3C, 8'hA5); rd(8'h3C); idle();
      cur_req = "R7";  wr(8'h20, 8'hFF); wr(8'h24, 8'hFF); wr(8'h5C, 8'hFF); wr(8'h4C, 8'hFF);
                       wr(8'h54, 8'hFC); wr(8'h40, 8'h9C); wr(8'h48, 8'h3E); wr(8'h60, 8'hC3);
                       rd(8'h20); rd(8'h24); rd(8'h5C); rd(8'h4C); rd(8'h54); rd(8'h40); rd(8'h48); rd(8'h60);
      cur_req = "R8";  wr(8'h0C, 8'hBF); wr(8'h54, 8'h02); rd(8'h54); rd(8'h08); rd(8'h5C); rd(8'h38);
                       rd(8'h20); rd(8'h24); rd(8'h40); rd(8'h18); rd(8'h10); idle();
      cur_req = "R13"; rd(8'h64); rd(8'h0D); wr(8'h80, 8'hFF); wr(8'h22, 8'h11); idle(); idle();
                       rd(8'h20); idle(); idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule